// File: doc/BRIEF.md
# Clock Synthesizer Configuration Register Bank with Two-Wire Target

This block is the serial configuration front end of a video clock synthesizer. It acts as a target on a two-wire I2C bus and holds the registers that steer the rest of the synthesizer. These registers cover input polarity and selection, the loop settings, the feedback divider, the phase-delay settings, the output enables and the oscillator divider. A strap input picks one of two bus addresses, so two synthesizers can share one bus.

Eight control registers can be written and read back. Four of them are double-buffered: the loop control, both feedback-divider bytes and the phase-delay resolution. A write changes only the pending copy. The value reaches the synthesizer only when the master writes a matching pattern to a write-only command register. One nibble of that pattern commits the loop group and the other nibble commits the resolution register. Three read-only registers return a version byte, a revision byte and the PLL lock flag.

The register index advances after every data byte, but only its low nibble counts and it wraps within the nibble. A master must therefore send a new index to move from the control group to the identification group. Both bus lines pass through a synchronizer and a glitch filter clocked by a system clock that runs at least ten times faster than SCL.

Top module: `clksyn_regbank`

## Requirements
- R1: The target acknowledges address byte {6'b010011, addr_sel_i, rw}: 4Ch/4Dh with the strap low and 4Eh/4Fh with it high. Any other address is left unacknowledged, and the bytes that follow it up to the next start are ignored.
- R2: A write sends the address with rw=0, then an index byte, then data bytes. The target acknowledges each of these bytes and stores each data byte at the current index.
- R3: After reset, byte k of cfg_o (bits 8k+7:8k) holds register k: 0x0=41h, 0x2=FFh, 0x3=0Fh, 0x5=03h, 0x7=80h, and all other bytes 00h.
- R4: After each data byte, read or written, index bits 3:0 increment modulo 16 and bits 7:4 stay unchanged. Index 0x0F is followed by 0x00 and 0x1F by 0x10.
- R5: Writes to registers 0x1, 0x2, 0x3 and 0x5 change only the pending copy. Readback returns the pending copy, and cfg_o keeps the committed value.
- R6: Writing a byte with low nibble Ah to index 0x08 commits the pending 0x5 into cfg_o. The loop group does not change unless the high nibble is also 5h.
- R7: Writing a byte with high nibble 5h to index 0x08 commits the pending 0x1 to 0x3 into cfg_o. Register 0x5 does not change unless the low nibble is also Ah.
- R8: Index 0x10 reads 17h, index 0x11 reads 01h, and index 0x12 reads {6'b0, pll_lock_i, 1'b0}.
- R9: Index 0x08 and all indices outside 0x00 to 0x08 and 0x10 to 0x12 read 00h. Writes to unmapped indices change no register.
- R10: A read sends the index with a write, then a repeated start and the address with rw=1. Data goes out MSB first. The master acknowledges every byte except the last, which it leaves unacknowledged. After that NACK the target releases SDA and changes SDA only while SCL is low.
- R11: Registers 0x0, 0x4, 0x6 and 0x7 appear in cfg_o as soon as the write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_sel_i | input | 1 | Strap that selects bus address bit 0 |
| pll_lock_i | input | 1 | Lock flag from the PLL, asynchronous |
| cfg_o | output | 64 | Committed register values, byte k = register k |

## Verification
The bench aims at the index wrap in both directions. It reads 0x1F then 0x10, and writes 0x0F then 0x00. A design that carried into the high nibble would return 00h where 17h is expected, or would leave register 0 unchanged. The commit patterns 50h, 0Ah and 5Ah are sent after pending writes, so a design that mixed up the two groups or committed on every write would show wrong cfg_o bytes. A foreign address is followed by a full write sequence to check that it is ignored. Unmapped writes are checked against a snapshot of cfg_o and by reading those indices back.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } bus_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_INDEX,
    RL_DATA
  } rx_role_e;

  localparam int unsigned NUM_RW    = 8;
  localparam logic [7:0]  CMD_IDX   = 8'h08;
  localparam logic [7:0]  VER_IDX   = 8'h10;
  localparam logic [7:0]  REV_IDX   = 8'h11;
  localparam logic [7:0]  STAT_IDX  = 8'h12;
  localparam logic [3:0]  DPA_NIB   = 4'hA;
  localparam logic [3:0]  LOOP_NIB  = 4'h5;
  // registers committed by the loop pattern and by the delay pattern
  localparam logic [NUM_RW-1:0] LOOP_GRP = 8'b0000_1110;
  localparam logic [NUM_RW-1:0] DPA_GRP  = 8'b0010_0000;

  function automatic logic [7:0] rw_reset(input int unsigned k);
    case (k)
      0:       return 8'h41;
      2:       return 8'hFF;
      3:       return 8'h0F;
      5:       return 8'h03;
      7:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] nib_inc(input logic [7:0] idx);
    return {idx[7:4], idx[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          agree_cnt;
  logic                   samp;

  assign samp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '1;
      agree_cnt <= '0;
      dout      <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (samp == dout) begin
        agree_cnt <= '0;
      end else if (agree_cnt == CW'(FILT_LEN - 1)) begin
        dout      <= samp;
        agree_cnt <= '0;
      end else begin
        agree_cnt <= agree_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import clksyn_pkg::*;
#(
  parameter logic [6:0] DEV_BASE = 7'h26
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] idx,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data
);
  bus_state_e st;
  rx_role_e   role;
  logic       rd_mode;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       scl_q, sda_q;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic [6:0] dev_addr;

  assign dev_addr = {DEV_BASE[6:1], addr_sel};
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      st      <= ST_IDLE;
      role    <= RL_ADDR;
      rd_mode <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      idx     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (start_c) begin
        st     <= ST_RX;
        role   <= RL_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              case (role)
                RL_ADDR: begin
                  if (sh[7:1] == dev_addr) begin
                    rd_mode <= sh[0];
                    sda_oe  <= 1'b1;
                    st      <= ST_ACK_OUT;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                RL_INDEX: begin
                  idx    <= sh;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK_OUT;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= idx;
                  wr_data <= sh;
                  idx     <= nib_inc(idx);
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK_OUT;
                end
              endcase
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              cnt <= '0;
              if (role == RL_ADDR && rd_mode) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                idx    <= nib_inc(idx);
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                role   <= (role == RL_ADDR) ? RL_INDEX : RL_DATA;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_ACK_IN;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              if (sda_f) st <= ST_IDLE;
            end else if (scl_fall) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              idx    <= nib_inc(idx);
              cnt    <= '0;
              st     <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  foreign_addr_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RX && role == RL_ADDR && scl_fall && cnt == 4'd8 && sh[7:1] != dev_addr)
    |=> !sda_oe);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f);

  // R10
  nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK_IN && scl_rise && sda_f) |=> !sda_oe);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import clksyn_pkg::*;
#(
  parameter logic [7:0] CHIP_VER = 8'h17,
  parameter logic [7:0] CHIP_REV = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  input  logic                  pll_lock,
  output logic [7:0]            rd_data,
  output logic [8*NUM_RW-1:0]   cfg_o
);
  localparam int unsigned IW = $clog2(NUM_RW);
  localparam logic [NUM_RW-1:0] DBUF = LOOP_GRP | DPA_GRP;

  logic [8*NUM_RW-1:0] pend_v;
  logic                cmd_wr;
  logic [1:0]          lock_s;

  assign cmd_wr = wr_en && (wr_idx == CMD_IDX);

  always_ff @(posedge clk) begin
    if (rst) lock_s <= '0;
    else     lock_s <= {lock_s[0], pll_lock};
  end

  for (genvar k = 0; k < NUM_RW; k++) begin : g_reg
    logic [7:0] pend_q;

    always_ff @(posedge clk) begin
      if (rst)                              pend_q <= rw_reset(k);
      else if (wr_en && wr_idx == 8'(k))    pend_q <= wr_data;
    end
    assign pend_v[8*k +: 8] = pend_q;

    if (DBUF[k]) begin : g_dbuf
      logic [7:0] live_q;
      logic       commit;
      assign commit = cmd_wr &&
                      ((LOOP_GRP[k] && wr_data[7:4] == LOOP_NIB) ||
                       (DPA_GRP[k]  && wr_data[3:0] == DPA_NIB));
      always_ff @(posedge clk) begin
        if (rst)         live_q <= rw_reset(k);
        else if (commit) live_q <= pend_q;
      end
      assign cfg_o[8*k +: 8] = live_q;

      // R5
      pend_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 8'(k)) |=> $stable(cfg_o[8*k +: 8]));
    end else begin : g_direct
      assign cfg_o[8*k +: 8] = pend_q;

      // R11
      direct_upd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 8'(k)) |=> (cfg_o[8*k +: 8] == $past(wr_data)));
    end

    // R3
    rst_val_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (cfg_o[8*k +: 8] == rw_reset(k)));
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx < 8'(NUM_RW)) begin
      rd_data = pend_v[8*rd_idx[IW-1:0] +: 8];
    end else begin
      case (rd_idx)
        VER_IDX:  rd_data = CHIP_VER;
        REV_IDX:  rd_data = CHIP_REV;
        STAT_IDX: rd_data = {6'b0, lock_s[1], 1'b0};
        default:  rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/clksyn_regbank.sv
module clksyn_regbank
  import clksyn_pkg::*;
#(
  parameter logic [6:0]  DEV_BASE    = 7'h26,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic                addr_sel_i,
  input  logic                pll_lock_i,
  output logic [8*NUM_RW-1:0] cfg_o
);
  logic       scl_f, sda_f;
  logic [7:0] rd_data, idx, wr_idx, wr_data;
  logic       wr_en;

  i2c_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_flt (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_f));

  i2c_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_flt (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_f));

  i2c_target #(.DEV_BASE(DEV_BASE)) u_target (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .addr_sel(addr_sel_i),
    .rd_data(rd_data), .idx(idx), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  cfg_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(idx), .pll_lock(pll_lock_i), .rd_data(rd_data), .cfg_o(cfg_o));
endmodule

// File: tb/sim_clksyn_regbank.sv
`timescale 1ns/1ps
module sim_clksyn_regbank;
  localparam int Q = 50;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, lock = 1'b0;
  logic sda_oe, sda_line;
  logic [63:0] cfg;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  clksyn_regbank u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .pll_lock_i(lock), .cfg_o(cfg));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic expect_b(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // monitor: compares each byte read off the bus with the next expected item
  initial forever begin
    logic [7:0] g, e;
    string t;
    wait (got_q.size() != 0);
    g = got_q.pop_front();
    if (exp_q.size() == 0) begin
      chk("R10 unexpected read byte", {56'b0, g}, 64'hx);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {56'b0, g}, {56'b0, e});
    end
  end

  task automatic m_start();
    sda_m = 1; scl_m = 1; #Q; sda_m = 0; #Q; scl_m = 0; #Q;
  endtask
  task automatic m_rstart();
    sda_m = 1; #Q; scl_m = 1; #Q; sda_m = 0; #Q; scl_m = 0; #Q;
  endtask
  task automatic m_stop();
    sda_m = 0; #Q; scl_m = 1; #Q; sda_m = 1; #(4*Q);
  endtask
  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1; #(2*Q); scl_m = 0; #Q;
    end
    sda_m = 1; #Q; scl_m = 1; #Q; ack = ~sda_line; #Q; scl_m = 0; #Q;
  endtask
  task automatic m_recv(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl_m = 1; #Q; b[i] = sda_line; #Q; scl_m = 0; #Q;
    end
    sda_m = ~give_ack; #Q; scl_m = 1; #(2*Q); scl_m = 0; #Q; sda_m = 1;
  endtask

  task automatic wr(input logic [7:0] dev, input logic [7:0] idx,
                    input logic [7:0] d [4], input int n);
    logic a;
    m_start();
    m_send(dev, a);   chk("R2 write address ack", a, 1);
    m_send(idx, a);   chk("R2 index ack", a, 1);
    for (int i = 0; i < n; i++) begin
      m_send(d[i], a); chk("R2 data ack", a, 1);
    end
    m_stop();
  endtask

  task automatic rd(input logic [7:0] dev, input logic [7:0] idx, input int n);
    logic a;
    logic [7:0] b;
    m_start();
    m_send(dev, a);          chk("R10 address ack", a, 1);
    m_send(idx, a);          chk("R10 index ack", a, 1);
    m_rstart();
    m_send(dev | 8'h01, a);  chk("R10 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      m_recv(i < n - 1, b);
      got_q.push_back(b);
    end
    m_stop();
    chk("R10 sda released after nack", {63'b0, sda_oe}, 64'h0);
  endtask

  initial begin
    logic a;
    logic [63:0] snap;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R3 reset image", cfg, 64'h80_00_03_00_0F_FF_00_41);
    chk("R3 sda idle", {63'b0, sda_oe}, 64'h0);

    // R3 readback of whole control group
    expect_b(8'h41, "R3 reg0"); expect_b(8'h00, "R3 reg1");
    expect_b(8'hFF, "R3 reg2"); expect_b(8'h0F, "R3 reg3");
    expect_b(8'h00, "R3 reg4"); expect_b(8'h03, "R3 reg5");
    expect_b(8'h00, "R3 reg6"); expect_b(8'h80, "R3 reg7");
    rd(8'h4C, 8'h00, 8);

    // R8 identification and lock status
    expect_b(8'h17, "R8 version"); expect_b(8'h01, "R8 revision");
    expect_b(8'h00, "R8 unlocked");
    rd(8'h4C, 8'h10, 3);
    lock = 1;
    #(10*Q);
    expect_b(8'h02, "R8 locked");
    rd(8'h4C, 8'h12, 1);

    // R4 read wrap from 0x1F to 0x10
    expect_b(8'h00, "R4 idx 1F"); expect_b(8'h17, "R4 wrap to 10");
    rd(8'h4C, 8'h1F, 2);

    // R1 foreign address ignored
    m_start();
    m_send(8'h4E, a); chk("R1 foreign address nack", a, 0);
    m_send(8'h00, a);
    m_send(8'h99, a);
    m_stop();
    chk("R1 foreign write ignored", cfg, 64'h80_00_03_00_0F_FF_00_41);
    addr_sel = 1;
    m_start();
    m_send(8'h4C, a); chk("R1 low address nack with strap high", a, 0);
    m_stop();
    wr(8'h4E, 8'h00, '{8'h99, 8'h0, 8'h0, 8'h0}, 1);
    chk("R1 strap high write", {56'b0, cfg[7:0]}, 64'h99);
    expect_b(8'h99, "R1 strap high read");
    rd(8'h4E, 8'h00, 1);
    addr_sel = 0;

    // R11 direct registers
    wr(8'h4C, 8'h06, '{8'h1F, 8'h7F, 8'h0, 8'h0}, 2);
    chk("R11 reg6 live", {56'b0, cfg[55:48]}, 64'h1F);
    chk("R11 reg7 live", {56'b0, cfg[63:56]}, 64'h7F);
    wr(8'h4C, 8'h04, '{8'h2A, 8'h0, 8'h0, 8'h0}, 1);
    chk("R11 reg4 live", {56'b0, cfg[39:32]}, 64'h2A);

    // R5 pending writes do not reach cfg_o
    wr(8'h4C, 8'h01, '{8'h33, 8'h44, 8'h05, 8'h0}, 3);
    wr(8'h4C, 8'h05, '{8'h01, 8'h0, 8'h0, 8'h0}, 1);
    chk("R5 loop group held", {40'b0, cfg[31:8]}, 64'h0F_FF_00);
    chk("R5 reg5 held", {56'b0, cfg[47:40]}, 64'h03);
    expect_b(8'h33, "R5 pending reg1"); expect_b(8'h44, "R5 pending reg2");
    expect_b(8'h05, "R5 pending reg3"); expect_b(8'h2A, "R5 reg4");
    expect_b(8'h01, "R5 pending reg5");
    rd(8'h4C, 8'h01, 5);

    // R7 loop commit only
    wr(8'h4C, 8'h08, '{8'h50, 8'h0, 8'h0, 8'h0}, 1);
    chk("R7 loop group committed", {40'b0, cfg[31:8]}, 64'h05_44_33);
    chk("R7 reg5 untouched", {56'b0, cfg[47:40]}, 64'h03);

    // R6 delay-resolution commit only
    wr(8'h4C, 8'h01, '{8'h77, 8'h0, 8'h0, 8'h0}, 1);
    wr(8'h4C, 8'h08, '{8'h0A, 8'h0, 8'h0, 8'h0}, 1);
    chk("R6 reg5 committed", {56'b0, cfg[47:40]}, 64'h01);
    chk("R6 loop group untouched", {56'b0, cfg[15:8]}, 64'h33);
    wr(8'h4C, 8'h05, '{8'h00, 8'h0, 8'h0, 8'h0}, 1);
    wr(8'h4C, 8'h08, '{8'h5A, 8'h0, 8'h0, 8'h0}, 1);
    chk("R6 combined commit reg5", {56'b0, cfg[47:40]}, 64'h00);
    chk("R7 combined commit reg1", {56'b0, cfg[15:8]}, 64'h77);

    // R9 unmapped writes and reads
    snap = cfg;
    wr(8'h4C, 8'h09, '{8'h77, 8'h0, 8'h0, 8'h0}, 1);
    wr(8'h4C, 8'h1E, '{8'h66, 8'h0, 8'h0, 8'h0}, 1);
    chk("R9 unmapped writes ignored", cfg, snap);
    expect_b(8'h00, "R9 idx 09 reads zero");
    rd(8'h4C, 8'h09, 1);
    expect_b(8'h00, "R9 command reads zero");
    rd(8'h4C, 8'h08, 1);
    expect_b(8'h00, "R9 idx 13 reads zero");
    rd(8'h4C, 8'h13, 1);

    // R4 write wrap from 0x0F to 0x00
    snap = cfg;
    wr(8'h4C, 8'h0F, '{8'hAA, 8'h3C, 8'h0, 8'h0}, 2);
    chk("R4 write wrapped into reg0", cfg, {snap[63:8], 8'h3C});
    expect_b(8'h00, "R4 idx 0F"); expect_b(8'h3C, "R4 wrap to 00");
    rd(8'h4C, 8'h0F, 2);

    #(10*Q);
    chk("R10 scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule